// File: doc/BRIEF.md
# Radix-4 Signed-Digit Iterative Divider

This block divides an unsigned dividend by a normalized unsigned divisor. Both operands are `N` bits wide, and the divisor's top bit must be set. Each clock cycle runs one radix-4 recurrence step. The block keeps a two's-complement partial remainder. At each step it picks a quotient digit from {-2,-1,0,1,2}, using a small combinational selection function. The inputs to that function are the six top bits of the remainder and the three divisor bits just below its leading one. The next remainder is four times the remainder minus the digit-weighted divisor. Because the digit set is redundant, the remainder may go negative, but it always stays within eight thirds of the divisor in magnitude.

After `K = ceil(N/2)` steps, a separate conversion stage turns the stored signed digits into a binary quotient. Each digit is weighted by a power of four, and the first digit is the most significant. If the last remainder is negative, the conversion stage adds the divisor back and lowers the quotient by one. The results are a fixed-point quotient `Q = floor(X * 4^(K-1) / D)` and a remainder `R` that satisfy `X * 4^(K-1) = Q*D + R` with `0 <= R < D`.

A caller pulses `start_i` while the block is idle. Some cycles later a one-cycle `done_o` pulse marks the new results. A divisor whose top bit is clear, which includes zero, raises a one-cycle error flag and starts no division.

Top module: `srt4_divider`

## Requirements
- R1: While reset is applied and after it is released, `busy_o`, `done_o` and `err_o` are 0, and `quot_o` and `rem_o` are 0.
- R2: A `start_i` sampled while idle with `divisor_i[N-1]=1` makes `busy_o` 1 after that edge. `done_o` rises exactly `K+1` rising edges after the accepting edge, and `busy_o` is 0 in the cycle where `done_o` is 1.
- R3: When `done_o` is 1, `quot_o = floor(X*4^(K-1)/D)` and `rem_o = X*4^(K-1) - quot_o*D`, with `0 <= rem_o < D`. For the default `N=8` (`K=4`) this means `quot_o = floor(X*64/D)`. The relation holds at the extremes: `X=0`, the largest `X`, the smallest and largest normalized `D`, and `X=D`.
- R4: `done_o` is high for exactly one cycle per division. `quot_o` and `rem_o` keep their values until the next completion.
- R5: A `start_i` that arrives while `busy_o` is 1 is ignored. The running division completes with its own operands, and no second completion follows.
- R6: A `start_i` sampled while idle with `divisor_i[N-1]=0` (including a zero divisor) raises `err_o` for one cycle after that edge. `busy_o` stays 0, `done_o` stays 0 and the previous `quot_o`/`rem_o` are unchanged. A valid start leaves `err_o` at 0.
- R7: Before every recurrence step the partial remainder `P` satisfies `-8D <= 3P <= 8D`.
- R8: Each selected digit is a 3-bit sign-magnitude code: bit 2 is the sign (1 means negative) and bits 1:0 are the magnitude. The magnitude is at most 2, and a negative zero is never produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request to begin a division; sampled only while idle |
| dividend_i | input | N | Unsigned dividend X |
| divisor_i | input | N | Unsigned divisor D; its top bit must be 1 |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle pulse: `quot_o` and `rem_o` hold a new result |
| err_o | output | 1 | One-cycle pulse: a start was refused because the divisor was not normalized |
| quot_o | output | 2K-1 | Fixed-point quotient `floor(X*4^(K-1)/D)` |
| rem_o | output | N | Remainder, `0 <= rem_o < D` |

## Verification
The remainder-bound and digit-range assertions assume that every accepted divisor has its top bit set and that the divisor register stays constant while a division runs. The bench keeps to these conditions by giving the block only normalized divisors for real divisions. It sends unnormalized and zero divisors only to test the refusal path, which never enters the recurrence. The bench also drives its late starts while the block is busy, so the operand capture register must stay unchanged. Together these cases cover the end points of the selection regions: the smallest and largest divisor, a zero dividend and a full-scale dividend.

// File: rtl/srt4_pkg.sv
package srt4_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIN  = 2'd2
  } srt_state_t;

  // Signed quotient digit: sign bit, then magnitude 0..2.
  typedef struct packed {
    logic       neg;
    logic [1:0] mag;
  } sdigit_t;

  // Lower bound, in steps of 1/8, that the truncated shifted remainder must
  // reach for digit q to be chosen over q-1. The divisor estimate dh is in
  // steps of 1/16 (range 8..15). The bound is rounded up to the estimate grid.
  function automatic int sel_thr(input int q, input int dh);
    int dsel;
    int num;
    dsel = (q > 0) ? dh + 1 : dh;
    num  = (3 * q - 2) * dsel;
    if (num > 0) return (num + 5) / 6;
    else         return num / 6;
  endfunction

endpackage

// File: rtl/srt4_digit_sel.sv
module srt4_digit_sel
  import srt4_pkg::*;
(
  input  logic [5:0] p_est,
  input  logic [2:0] d_est,
  output sdigit_t    dig
);

  localparam int NCOL = 8;

  int      pe;
  sdigit_t col [NCOL];

  always_comb pe = int'($signed(p_est));

  // One comparator column for each divisor estimate value.
  for (genvar g = 0; g < NCOL; g++) begin : g_col
    localparam int DH  = 8 + g;
    localparam int M2  = sel_thr(2, DH);
    localparam int M1  = sel_thr(1, DH);
    localparam int M0  = sel_thr(0, DH);
    localparam int MN1 = sel_thr(-1, DH);
    assign col[g] = (pe >= M2)  ? {1'b0, 2'd2} :
                    (pe >= M1)  ? {1'b0, 2'd1} :
                    (pe >= M0)  ? {1'b0, 2'd0} :
                    (pe >= MN1) ? {1'b1, 2'd1} :
                                  {1'b1, 2'd2};
  end

  always_comb dig = col[d_est];

endmodule

// File: rtl/srt4_step.sv
module srt4_step
  import srt4_pkg::*;
#(
  parameter int N = 8,
  parameter int W = N + 3
) (
  input  logic signed [W-1:0] p,
  input  logic [N-1:0]        d,
  input  sdigit_t             dig,
  output logic signed [W-1:0] diff
);

  logic [W-1:0] mult;

  // Divisor multiple: zero, D, or 2D by a shift.
  always_comb begin
    case (dig.mag)
      2'd1:    mult = W'(d);
      2'd2:    mult = W'({d, 1'b0});
      default: mult = '0;
    endcase
  end

  always_comb begin
    if (dig.neg) diff = p + $signed(mult);
    else         diff = p - $signed(mult);
  end

endmodule

// File: rtl/srt4_qconv.sv
module srt4_qconv #(
  parameter int N  = 8,
  parameter int K  = (N + 1) / 2,
  parameter int W  = N + 3,
  parameter int QW = 2 * K - 1
) (
  input  logic [K-1:0][2:0]   digs,
  input  logic signed [W-1:0] rem_raw,
  input  logic [N-1:0]        d,
  output logic [QW-1:0]       quot,
  output logic [N-1:0]        rem
);

  logic [2*K-1:0] pos_v;
  logic [2*K-1:0] neg_v;
  logic           fix;

  // Digit i carries weight 4^(K-1-i). Positive and negative digits are
  // split into two plain binary vectors.
  for (genvar i = 0; i < K; i++) begin : g_split
    assign pos_v[2*(K-1-i) +: 2] = digs[i][2] ? 2'b00 : digs[i][1:0];
    assign neg_v[2*(K-1-i) +: 2] = digs[i][2] ? digs[i][1:0] : 2'b00;
  end

  assign fix = rem_raw[W-1];

  // The final result lies in range, so arithmetic modulo the output width is exact.
  always_comb begin
    quot = QW'(pos_v - neg_v - {{(2*K-1){1'b0}}, fix});
    rem  = N'(rem_raw + (fix ? $signed(W'(d)) : $signed(W'(0))));
  end

endmodule

// File: rtl/srt4_divider.sv
module srt4_divider
  import srt4_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [N-1:0]           dividend_i,
  input  logic [N-1:0]           divisor_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [2*((N+1)/2)-2:0] quot_o,
  output logic [N-1:0]           rem_o
);

  localparam int K  = (N + 1) / 2;
  localparam int W  = N + 3;
  localparam int QW = 2 * K - 1;
  localparam int CW = (K > 1) ? $clog2(K) : 1;

  // Asynchronous assert, synchronous release.
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  srt_state_t         st_q, st_n;
  logic signed [W-1:0] p_q, p_n, p_diff;
  logic [N-1:0]       d_q;
  logic [CW-1:0]      cnt_q;
  logic [K-1:0][2:0]  digs_q;
  logic [QW-1:0]      quot_q, quot_c;
  logic [N-1:0]       rem_q, rem_c;
  logic               done_q, err_q, err_n;
  logic               load_en, step_en, fin_en, last;
  sdigit_t            dig;

  assign last = (cnt_q == CW'(K - 1));

  srt4_digit_sel u_sel (
    .p_est (p_q[W-1 -: 6]),
    .d_est (d_q[N-2 -: 3]),
    .dig   (dig)
  );

  srt4_step #(.N(N), .W(W)) u_step (
    .p    (p_q),
    .d    (d_q),
    .dig  (dig),
    .diff (p_diff)
  );

  srt4_qconv #(.N(N), .K(K), .W(W), .QW(QW)) u_conv (
    .digs    (digs_q),
    .rem_raw (p_q),
    .d       (d_q),
    .quot    (quot_c),
    .rem     (rem_c)
  );

  // Next-state logic
  always_comb begin
    st_n    = st_q;
    load_en = 1'b0;
    step_en = 1'b0;
    fin_en  = 1'b0;
    err_n   = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          if (divisor_i[N-1]) begin
            load_en = 1'b1;
            st_n    = S_RUN;
          end else begin
            err_n = 1'b1;
          end
        end
      end
      S_RUN: begin
        step_en = 1'b1;
        if (last) st_n = S_FIN;
      end
      S_FIN: begin
        fin_en = 1'b1;
        st_n   = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  // Remainder update: shift by four except on the last step, which keeps
  // the unshifted remainder for the conversion stage.
  always_comb begin
    if (load_en)   p_n = $signed({3'b000, dividend_i});
    else if (last) p_n = p_diff;
    else           p_n = {p_diff[W-3:0], 2'b00};
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= S_IDLE;
      p_q    <= '0;
      d_q    <= '0;
      cnt_q  <= '0;
      digs_q <= '0;
      quot_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= fin_en;
      err_q  <= err_n;
      if (load_en || step_en) p_q <= p_n;
      if (load_en) d_q <= divisor_i;
      if (load_en)      cnt_q <= '0;
      else if (step_en) cnt_q <= cnt_q + 1'b1;
      if (step_en) digs_q[cnt_q] <= dig;
      if (fin_en) begin
        quot_q <= quot_c;
        rem_q  <= rem_c;
      end
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
  assign quot_o = quot_q;
  assign rem_o  = rem_q;

  // Assertions
  logic signed [W+3:0] pw, p3, d8;
  always_comb begin
    pw = {{4{p_q[W-1]}}, p_q};
    p3 = pw + pw + pw;
    d8 = $signed({{(W+4-N){1'b0}}, d_q}) <<< 3;
  end

  a_r7_rem_bound: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == S_RUN) |-> ((p3 <= d8) && (p3 >= -d8)));

  a_r8_digit_range: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == S_RUN) |-> ((dig.mag != 2'b11) && !(dig.neg && dig.mag == 2'b00)));

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy_o && start_i && divisor_i[N-1]) |=> (busy_o && !err_o));

  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |=> !done_o);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !done_o |-> ($stable(quot_o) && $stable(rem_o)));

  a_r5_divisor_held: assert property (@(posedge clk) disable iff (!rst_sn)
    ((st_q == S_RUN) && $past(st_q == S_RUN)) |-> $stable(d_q));

  a_r6_refuse: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy_o && start_i && !divisor_i[N-1]) |=> (err_o && !busy_o && !done_o));

  a_r3_rem_range: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |-> (rem_o < d_q));

endmodule

// File: tb/srt4_divider_test.sv
module srt4_divider_test;

  localparam int N  = 8;
  localparam int K  = (N + 1) / 2;
  localparam int QW = 2 * K - 1;
  localparam int NV = 10;

  // {dividend, divisor, quotient, remainder}; quotient = floor(X*64/D)
  localparam logic [31:0] VEC [NV] = '{
    {8'd0,   8'd128, 8'd0,   8'd0},
    {8'd255, 8'd128, 8'd127, 8'd64},
    {8'd255, 8'd255, 8'd64,  8'd0},
    {8'd1,   8'd255, 8'd0,   8'd64},
    {8'd200, 8'd150, 8'd85,  8'd50},
    {8'd100, 8'd129, 8'd49,  8'd79},
    {8'd77,  8'd200, 8'd24,  8'd128},
    {8'd254, 8'd129, 8'd126, 8'd2},
    {8'd128, 8'd192, 8'd42,  8'd128},
    {8'd37,  8'd241, 8'd9,   8'd199}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [N-1:0]  dividend, divisor;
  logic          busy, done, err;
  logic [QW-1:0] quot;
  logic [N-1:0]  rem;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  srt4_divider #(.N(N)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .dividend_i (dividend),
    .divisor_i  (divisor),
    .busy_o     (busy),
    .done_o     (done),
    .err_o      (err),
    .quot_o     (quot),
    .rem_o      (rem)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_op(input logic [N-1:0] x, input logic [N-1:0] d);
    @(negedge clk);
    dividend = x;
    divisor  = d;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    int seen;
    rst_n = 1'b0; start = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 err in reset", err, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 quot after reset", quot, 0);
    chk("R1 rem after reset", rem, 0);
    chk("R1 busy after reset", busy, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      start_op(VEC[i][31:24], VEC[i][23:16]);
      chk("R2 busy after accept", busy, 1);
      chk("R6 no err on valid start", err, 0);
      wait_done(lat);
      chk("R2 latency", lat, K + 1);
      chk("R2 idle at done", busy, 0);
      chk("R3/R7/R8 quotient", quot, VEC[i][15:8]);
      chk("R3/R7/R8 remainder", rem, VEC[i][7:0]);
      @(negedge clk);
      chk("R4 done one cycle", done, 0);
      chk("R4 quotient held", quot, VEC[i][15:8]);
      chk("R4 remainder held", rem, VEC[i][7:0]);
    end

    // Start while busy is ignored
    start_op(8'd200, 8'd150);
    dividend = 8'd10; divisor = 8'd250; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R5 still busy", busy, 1);
    wait_done(lat);
    chk("R5 latency unchanged", lat, K);
    chk("R5 quotient of first op", quot, 85);
    chk("R5 remainder of first op", rem, 50);
    seen = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (done || busy) seen++;
    end
    chk("R5 no second run", seen, 0);

    // Unnormalized and zero divisors
    start_op(8'd90, 8'd127);
    chk("R6 err pulse", err, 1);
    chk("R6 not busy", busy, 0);
    @(negedge clk);
    chk("R6 err one cycle", err, 0);
    start_op(8'd90, 8'd0);
    chk("R6 err on zero divisor", err, 1);
    chk("R6 not busy on zero", busy, 0);
    seen = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (done || busy) seen++;
    end
    chk("R6 no completion", seen, 0);
    chk("R6 quotient unchanged", quot, 85);
    chk("R6 remainder unchanged", rem, 50);

    // Boundary: X equals D, smallest normalized divisor
    start_op(8'd128, 8'd128);
    wait_done(lat);
    chk("R3 X=D quotient", quot, 64);
    chk("R3 X=D remainder", rem, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule